// File: doc/BRIEF.md
# Scanline Interrupt Generator

This block lets a CPU request an interrupt at a chosen line of a video frame. A renderer supplies a dot-advance strobe, the current dot and line numbers, and a flag that says whether rendering is on. Once per line, at one fixed dot, the block looks at the next line number and updates its state. The first line seen with rendering active starts a frame. Each line after that advances a counter. When the counter matches a target that the CPU programmed, a sticky pending flag is set.

Whenever rendering is off, or the next line falls into the vertical blanking region, the block drops out of the frame and clears its state. The CPU has two byte registers. One holds the target. The other is a control register on write and a status register on read, and a status read acknowledges the pending flag. An external interrupt source is ORed into the registered interrupt output.

Top module: `scanline_irq_gen`

## Requirements
- R1: The line state is evaluated only in a cycle where `dot_valid` is 1 and `dot_num` equals 336. A strobe at any other dot changes nothing.
- R2: An evaluation where `render_on` is 0, or where `line_num + 1` is 241 or more, clears the in-frame flag, the line counter and the pending flag.
- R3: An evaluation with rendering active while in-frame is 0 sets in-frame and clears the counter and pending flag, without counting that line.
- R4: Each later evaluation inside a frame increments the counter. When the incremented value equals the 8-bit target register, pending is set. The target is written at `cpu_addr` 0, and a target of 0 is never reached.
- R5: A write to `cpu_addr` 1 sets the interrupt enable from data bit 7.
- R6: With `cpu_addr` 1, `cpu_rdata` shows pending in bit 7 and in-frame in bit 6, with every other bit 0. A cycle with `cpu_rd` set at address 1 clears pending, unless pending is being set in that same cycle, in which case setting wins.
- R7: `irq` is registered. One cycle after pending AND enable, OR `ext_irq`, is true, `irq` is 1, and otherwise it is 0.
- R8: While `rst_n` is low, the flags, the counter, the target, the enable and `irq` all go to 0 at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dot_valid | input | 1 | The renderer advanced a dot this cycle |
| dot_num | input | 9 | Current horizontal dot |
| line_num | input | 9 | Current line |
| render_on | input | 1 | Rendering is enabled |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (side effect on status) |
| cpu_addr | input | 1 | 0 = target, 1 = control/status |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (status at address 1, otherwise 0) |
| ext_irq | input | 1 | External interrupt request merged into the output |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench walks one frame to the target and checks that the start line is not counted. A design that counted it would fire one line early. It checks that line 239 still counts and line 240 leaves the frame, which catches an off-by-one in the blanking compare, and that a strobe at dot 335 leaves the count alone. It issues a status read in the same cycle as a target hit. A design that gave the clear priority would lose that interrupt. With the enable low it checks that pending still rises while `irq` stays low, and that `ext_irq` reaches `irq` on its own.

// File: rtl/sl_irq_pkg.sv
// Shared types for the scanline interrupt generator.
// Assumes nothing beyond a common clock domain.
package sl_irq_pkg;
    // Outcome of one line evaluation
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_STOP  = 2'd1,
        EV_START = 2'd2,
        EV_COUNT = 2'd3
    } line_ev_t;
endpackage

// File: rtl/sl_line_eval.sv
// Decides, from the renderer timing inputs and the current in-frame flag,
// what a line evaluation does this cycle. Pure combinational logic.
// Assumes dot_valid pulses once per dot, so the evaluation dot fires once.
module sl_line_eval
    import sl_irq_pkg::*;
#(
    parameter int DOT_W      = 9,
    parameter int LINE_W     = 9,
    parameter int EVAL_DOT   = 336,
    parameter int BLANK_LINE = 241
) (
    input  logic              dot_valid,
    input  logic [DOT_W-1:0]  dot_num,
    input  logic [LINE_W-1:0] line_num,
    input  logic              render_on,
    input  logic              in_frame,
    output line_ev_t          ev
);
    localparam int NXT_W = LINE_W + 1;

    logic [NXT_W-1:0] next_line;
    logic             at_eval;
    logic             in_blank;

    // Next line number and the blanking test, one bit wider to avoid wrap
    always_comb begin
        next_line = {1'b0, line_num} + NXT_W'(1);
        in_blank  = next_line >= NXT_W'(BLANK_LINE);
        at_eval   = dot_valid && (dot_num == DOT_W'(EVAL_DOT));
    end

    // Classify the evaluation: stop beats start beats count
    always_comb begin
        if (!at_eval)
            ev = EV_NONE;
        else if (!render_on || in_blank)
            ev = EV_STOP;
        else if (!in_frame)
            ev = EV_START;
        else
            ev = EV_COUNT;
    end
endmodule

// File: rtl/sl_frame_counter.sv
// Holds the in-frame flag, the line counter and the sticky pending flag.
// A status-read clear loses to a target hit in the same cycle.
// Assumes ev comes from sl_line_eval and rd_clear is a one-cycle strobe.
module sl_frame_counter
    import sl_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  line_ev_t         ev,
    input  logic [CNT_W-1:0] target,
    input  logic             rd_clear,
    output logic             in_frame,
    output logic             pending
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_inc;
    logic             hit;

    // Incremented count and target comparison
    always_comb begin
        count_inc = count_q + CNT_W'(1);
        hit       = (ev == EV_COUNT) && (count_inc == target);
    end

    // Frame flag and counter update per evaluation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            count_q  <= '0;
        end else begin
            case (ev)
                EV_STOP: begin
                    in_frame <= 1'b0;
                    count_q  <= '0;
                end
                EV_START: begin
                    in_frame <= 1'b1;
                    count_q  <= '0;
                end
                EV_COUNT: count_q <= count_inc;
                default: ;
            endcase
        end
    end

    // Pending flag: cleared by stop/start, set by hit, else acked by read
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (ev == EV_STOP || ev == EV_START)
            pending <= 1'b0;
        else if (hit)
            pending <= 1'b1;
        else if (rd_clear)
            pending <= 1'b0;
    end
endmodule

// File: rtl/sl_cpu_regs.sv
// CPU-side registers: the target at address 0 and control/status at 1.
// Read data is combinational from the address; the read strobe only
// produces the acknowledge for the pending flag.
module sl_cpu_regs #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              pending,
    input  logic              in_frame,
    output logic [DATA_W-1:0] target,
    output logic              irq_en,
    output logic              rd_clear,
    output logic [DATA_W-1:0] cpu_rdata
);
    localparam logic [ADDR_W-1:0] A_TARGET = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(1);

    // Target and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= '0;
            irq_en <= 1'b0;
        end else if (cpu_wr) begin
            if (cpu_addr == A_TARGET)
                target <= cpu_wdata;
            if (cpu_addr == A_CTRL)
                irq_en <= cpu_wdata[DATA_W-1];
        end
    end

    // Status view and read acknowledge
    always_comb begin
        rd_clear  = cpu_rd && (cpu_addr == A_CTRL);
        cpu_rdata = '0;
        if (cpu_addr == A_CTRL) begin
            cpu_rdata[DATA_W-1] = pending;
            cpu_rdata[DATA_W-2] = in_frame;
        end
    end
endmodule

// File: rtl/scanline_irq_gen.sv
// Top level of the scanline interrupt generator: line evaluation,
// frame counter, CPU registers and a registered interrupt output.
// Assumes all inputs are synchronous to clk.
module scanline_irq_gen #(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 1,
    parameter int DOT_W      = 9,
    parameter int LINE_W     = 9,
    parameter int EVAL_DOT   = 336,
    parameter int BLANK_LINE = 241
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dot_valid,
    input  logic [DOT_W-1:0]  dot_num,
    input  logic [LINE_W-1:0] line_num,
    input  logic              render_on,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              ext_irq,
    output logic              irq
);
    import sl_irq_pkg::*;

    line_ev_t          ev;
    logic              in_frame;
    logic              pending;
    logic              irq_en;
    logic              rd_clear;
    logic [DATA_W-1:0] target;

    sl_line_eval #(
        .DOT_W(DOT_W), .LINE_W(LINE_W),
        .EVAL_DOT(EVAL_DOT), .BLANK_LINE(BLANK_LINE)
    ) u_eval (
        .dot_valid(dot_valid), .dot_num(dot_num), .line_num(line_num),
        .render_on(render_on), .in_frame(in_frame), .ev(ev)
    );

    sl_frame_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ev(ev), .target(target),
        .rd_clear(rd_clear), .in_frame(in_frame), .pending(pending)
    );

    sl_cpu_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .pending(pending),
        .in_frame(in_frame), .target(target), .irq_en(irq_en),
        .rd_clear(rd_clear), .cpu_rdata(cpu_rdata)
    );

    // Registered interrupt request
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= (pending && irq_en) || ext_irq;
    end
endmodule

// File: rtl/scanline_irq_gen_chk.sv
// Property checker for scanline_irq_gen, attached with bind.
module scanline_irq_gen_chk #(
    parameter int ADDR_W     = 1,
    parameter int DOT_W      = 9,
    parameter int LINE_W     = 9,
    parameter int EVAL_DOT   = 336,
    parameter int BLANK_LINE = 241
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dot_valid,
    input logic [DOT_W-1:0]  dot_num,
    input logic [LINE_W-1:0] line_num,
    input logic              render_on,
    input logic              cpu_rd,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              ext_irq,
    input logic              irq,
    input logic              in_frame,
    input logic              pending,
    input logic              irq_en
);
    logic eval_now;
    logic stop_now;
    assign eval_now = dot_valid && (dot_num == DOT_W'(EVAL_DOT));
    assign stop_now = eval_now &&
        (!render_on || ({1'b0, line_num} + (LINE_W+1)'(1)) >= (LINE_W+1)'(BLANK_LINE));

    // R1
    no_eval_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_now |=> $stable(in_frame));

    // R2
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_now |=> (!in_frame && !pending));

    // R3
    start_sets_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_now && !stop_now && !in_frame) |=> (in_frame && !pending));

    // R6
    read_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == ADDR_W'(1) && !eval_now) |=> !pending);

    // R7
    ext_reaches_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |=> irq);

    // R7
    quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_irq && !(pending && irq_en)) |=> !irq);

    // R8
    reset_irq_low_chk: assert property (@(posedge clk)
        !rst_n |=> !irq);
endmodule

bind scanline_irq_gen scanline_irq_gen_chk #(
    .ADDR_W(ADDR_W), .DOT_W(DOT_W), .LINE_W(LINE_W),
    .EVAL_DOT(EVAL_DOT), .BLANK_LINE(BLANK_LINE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dot_valid(dot_valid), .dot_num(dot_num),
    .line_num(line_num), .render_on(render_on), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .ext_irq(ext_irq), .irq(irq),
    .in_frame(in_frame), .pending(pending), .irq_en(irq_en)
);

// File: tb/scanline_irq_gen_tb.sv
`timescale 1ns/1ps
module scanline_irq_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       dot_valid;
    logic [8:0] dot_num;
    logic [8:0] line_num;
    logic       render_on;
    logic       cpu_wr;
    logic       cpu_rd;
    logic [0:0] cpu_addr;
    logic [7:0] cpu_wdata;
    logic [7:0] cpu_rdata;
    logic       ext_irq;
    logic       irq;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    scanline_irq_gen u_dut (
        .clk(clk), .rst_n(rst_n), .dot_valid(dot_valid), .dot_num(dot_num),
        .line_num(line_num), .render_on(render_on), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .ext_irq(ext_irq), .irq(irq)
    );

    // ops: 0 line evaluation, 1 write target, 2 write control, 3 status read
    // fields: [28:27] op, [26] render, [25:17] line, [16:9] data, [8:1] status, [0] irq
    localparam int NV = 22;
    localparam logic [28:0] VEC [NV] = '{
        {2'd2, 1'b0, 9'd0,   8'h80, 8'h00, 1'b0}, // R5 enable on
        {2'd1, 1'b0, 9'd0,   8'h03, 8'h00, 1'b0}, // R4 target 3
        {2'd0, 1'b1, 9'd0,   8'h00, 8'h40, 1'b0}, // R3 start, no count
        {2'd0, 1'b1, 9'd1,   8'h00, 8'h40, 1'b0}, // R4 count 1
        {2'd0, 1'b1, 9'd2,   8'h00, 8'h40, 1'b0}, // R4 count 2
        {2'd0, 1'b1, 9'd3,   8'h00, 8'hC0, 1'b1}, // R4 R7 count 3 hits
        {2'd0, 1'b1, 9'd4,   8'h00, 8'hC0, 1'b1}, // R4 pending sticky
        {2'd3, 1'b0, 9'd0,   8'h00, 8'h40, 1'b0}, // R6 read acks
        {2'd0, 1'b1, 9'd238, 8'h00, 8'h40, 1'b0}, // R4 count 5
        {2'd0, 1'b1, 9'd239, 8'h00, 8'h40, 1'b0}, // R2 next 240 still counts
        {2'd0, 1'b1, 9'd240, 8'h00, 8'h00, 1'b0}, // R2 next 241 stops
        {2'd0, 1'b1, 9'd261, 8'h00, 8'h00, 1'b0}, // R2 stays out
        {2'd0, 1'b1, 9'd0,   8'h00, 8'h40, 1'b0}, // R3 restart
        {2'd1, 1'b0, 9'd0,   8'h01, 8'h40, 1'b0}, // R4 target 1
        {2'd0, 1'b1, 9'd1,   8'h00, 8'hC0, 1'b1}, // R4 hit at 1
        {2'd0, 1'b0, 9'd2,   8'h00, 8'h00, 1'b0}, // R2 render off clears
        {2'd2, 1'b0, 9'd0,   8'h00, 8'h00, 1'b0}, // R5 enable off
        {2'd0, 1'b1, 9'd0,   8'h00, 8'h40, 1'b0}, // R3 start
        {2'd0, 1'b1, 9'd1,   8'h00, 8'hC0, 1'b0}, // R7 masked
        {2'd2, 1'b0, 9'd0,   8'h80, 8'hC0, 1'b1}, // R5 R7 enable releases
        {2'd3, 1'b0, 9'd0,   8'h00, 8'h40, 1'b0}, // R6 ack
        {2'd0, 1'b1, 9'd5,   8'h00, 8'h40, 1'b0}  // R4 count 2 no refire
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // One operation, then settle so the registered irq is visible
    task automatic drive(input logic strobe, input logic [8:0] dot, input logic rend,
                         input logic [8:0] ln, input logic wr, input logic rd,
                         input logic [0:0] addr, input logic [7:0] d);
        @(negedge clk);
        dot_valid = strobe; dot_num = dot; render_on = rend; line_num = ln;
        cpu_wr = wr; cpu_rd = rd; cpu_addr = addr; cpu_wdata = d;
        @(negedge clk);
        dot_valid = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_addr = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_vec(input logic [28:0] v);
        case (v[28:27])
            2'd0: drive(1'b1, 9'd336, v[26], v[25:17], 1'b0, 1'b0, 1'b1, 8'h00);
            2'd1: drive(1'b0, 9'd0, render_on, line_num, 1'b1, 1'b0, 1'b0, v[16:9]);
            2'd2: drive(1'b0, 9'd0, render_on, line_num, 1'b1, 1'b0, 1'b1, v[16:9]);
            default: drive(1'b0, 9'd0, render_on, line_num, 1'b0, 1'b1, 1'b1, 8'h00);
        endcase
    endtask

    initial begin
        #4000000;
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; dot_valid = 1'b0; dot_num = '0; line_num = '0;
        render_on = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_addr = 1'b1;
        cpu_wdata = '0; ext_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset status", cpu_rdata, 8'h00);
        check("R8 reset irq", {7'b0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i]);
            check($sformatf("vec%0d status R4/R6", i), cpu_rdata, VEC[i][8:1]);
            check($sformatf("vec%0d irq R7", i), {7'b0, irq}, {7'b0, VEC[i][0]});
        end

        // R1: strobe at dot 335 must not count (count stays 2)
        drive(1'b1, 9'd335, 1'b1, 9'd6, 1'b0, 1'b0, 1'b1, 8'h00);
        check("R1 off-dot status", cpu_rdata, 8'h40);
        drive(1'b0, 9'd0, 1'b1, 9'd6, 1'b1, 1'b0, 1'b0, 8'h03);
        drive(1'b1, 9'd336, 1'b1, 9'd6, 1'b0, 1'b0, 1'b1, 8'h00);
        check("R1 count was 2, now hits 3", cpu_rdata, 8'hC0);
        drive(1'b0, 9'd0, 1'b1, 9'd6, 1'b0, 1'b1, 1'b1, 8'h00);
        check("R6 ack after R1", cpu_rdata, 8'h40);

        // R6: read in same cycle as hit, set wins
        drive(1'b0, 9'd0, 1'b1, 9'd7, 1'b1, 1'b0, 1'b0, 8'h04);
        drive(1'b1, 9'd336, 1'b1, 9'd7, 1'b0, 1'b1, 1'b1, 8'h00);
        check("R6 set beats read clear", cpu_rdata, 8'hC0);
        check("R6 irq after simultaneous", {7'b0, irq}, 8'h01);

        // R7: external request alone
        drive(1'b0, 9'd0, 1'b1, 9'd7, 1'b1, 1'b0, 1'b1, 8'h00);
        drive(1'b0, 9'd0, 1'b1, 9'd7, 1'b0, 1'b1, 1'b1, 8'h00);
        check("R7 quiet before ext", {7'b0, irq}, 8'h00);
        @(negedge clk); ext_irq = 1'b1;
        @(negedge clk);
        check("R7 ext raises irq", {7'b0, irq}, 8'h01);
        ext_irq = 1'b0;
        @(negedge clk);
        check("R7 ext release", {7'b0, irq}, 8'h00);

        // R4: target 0 never fires over a full frame
        drive(1'b0, 9'd0, 1'b1, 9'd7, 1'b1, 1'b0, 1'b0, 8'h00);
        drive(1'b1, 9'd336, 1'b0, 9'd0, 1'b0, 1'b0, 1'b1, 8'h00);
        for (int ln = 0; ln < 240; ln++)
            drive(1'b1, 9'd336, 1'b1, 9'(ln), 1'b0, 1'b0, 1'b1, 8'h00);
        check("R4 target 0 never hit", cpu_rdata, 8'h40);

        // R8: reset mid-frame with pending and enable set
        drive(1'b0, 9'd0, 1'b1, 9'd0, 1'b1, 1'b0, 1'b0, 8'h01);
        drive(1'b0, 9'd0, 1'b1, 9'd0, 1'b1, 1'b0, 1'b1, 8'h80);
        drive(1'b1, 9'd336, 1'b0, 9'd0, 1'b0, 1'b0, 1'b1, 8'h00);
        drive(1'b1, 9'd336, 1'b1, 9'd0, 1'b0, 1'b0, 1'b1, 8'h00);
        drive(1'b1, 9'd336, 1'b1, 9'd1, 1'b0, 1'b0, 1'b1, 8'h00);
        check("R8 pre-reset pending", cpu_rdata, 8'hC0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R8 status after reset", cpu_rdata, 8'h00);
        check("R8 irq after reset", {7'b0, irq}, 8'h00);
        // enable was cleared: a hit now leaves irq low
        drive(1'b0, 9'd0, 1'b1, 9'd0, 1'b1, 1'b0, 1'b0, 8'h01);
        drive(1'b1, 9'd336, 1'b1, 9'd0, 1'b0, 1'b0, 1'b1, 8'h00);
        drive(1'b1, 9'd336, 1'b1, 9'd1, 1'b0, 1'b0, 1'b1, 8'h00);
        check("R8 enable reset to 0", {7'b0, irq}, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule